// File: doc/BRIEF.md
# Dadda Tree Unsigned Multiplier

This block multiplies two unsigned W-bit operands and delivers the full 2W-bit product. Every bit pair of the operands is ANDed into a partial-product matrix. The alignment of the partial products by weight is pure wiring. A chain of reduction layers then brings every column down to at most two bits. Each layer is built only from full adders (three bits in, sum and carry out) and half adders (two bits in). A final carry-propagate adder sums the two rows that remain.

Each layer follows the height-limit schedule. The limits start at 2 and each next limit is floor(1.5 × the previous one). Reduction begins at the largest limit that the tallest column exceeds, and each layer steps down one limit. Each column gets only the counters it needs to meet the current limit, counting the carries that arrive from the column below. All other bits pass through unchanged. This keeps the counter count to the minimum: W²−4W+3 full adders and W−1 half adders.

The schedule and the counter placement are computed during elaboration from W. With the default setting, one output register adds a cycle of latency and carries a valid flag alongside the product.

Top module: `dadda_mult`

## Requirements
- R1: With output registering on (REG_OUT=1), a product presented with op_vld high appears on prod one clock later and equals op_a × op_b as an unsigned 2W-bit value, for every operand pair of an 8-bit instance.
- R2: A 16-bit instance returns the exact 32-bit product for the corner operands 0, 1, 0x8000 and 0xFFFF in all pairings, and for pseudo-random operand pairs.
- R3: Product bit 0 equals op_a[0] AND op_b[0] of the operands captured.
- R4: If either captured operand is zero, the product is zero.
- R5: prod_vld equals op_vld delayed by exactly one clock.
- R6: While op_vld is low, prod keeps its previous value, whatever op_a and op_b do.
- R7: A clock edge with rst_n low clears prod to zero and prod_vld to 0, even when op_vld is high in that cycle.
- R8: The reduction uses exactly W²−4W+3 full adders and W−1 half adders: 35 and 7 for W=8, and 195 and 15 for W=16.
- R9: The number of reduction layers is the count of schedule limits below W. For W=16 that is six layers with column limits 13, 9, 6, 4, 3, 2 in that order. For W=8 it is four layers with limits 6, 4, 3, 2.
- R10: The all-ones square (2^W−1)² = 2^(2W) − 2^(W+1) + 1 is produced with its most significant bit set and no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | W | Unsigned multiplicand |
| op_b | input | W | Unsigned multiplier |
| op_vld | input | 1 | Operands valid; the product is captured on the next edge |
| prod | output | 2W | Unsigned product |
| prod_vld | output | 1 | Product valid, one clock after op_vld |

## Verification
Several properties are checked on every clock: the captured product against the arithmetic product, bit 0 against the AND of the operand LSBs, zero operands against a zero result, the one-cycle valid delay, holding while idle, and the reset values. Only the bench's scenarios can cover the rest. These are the exhaustive 8-bit sweep, the 16-bit corner and random operands, the all-ones square, a reset that lands while an operand is valid, and the layer schedule and counter totals that elaboration produces for both widths.

// File: rtl/dadda_pkg.sv
// Package dadda_pkg
// Elaboration-time planning for the Dadda reduction: the height-limit
// schedule, the layer count, and the counters that each column of each
// layer needs. Assumes W >= 3 and 2*W <= MAX_COLS.
package dadda_pkg;

    localparam int MAX_COLS = 128;

    // k-th schedule limit: 2, 3, 4, 6, 9, 13, 19, ...
    function automatic int d_limit(input int k);
        int d;
        d = 2;
        for (int i = 1; i < k; i++) d = (d * 3) / 2;
        return d;
    endfunction

    // Number of reduction layers needed for a W-bit operand
    function automatic int n_layers(input int w);
        int n;
        n = 0;
        while (d_limit(n + 1) < w) n++;
        return n;
    endfunction

    // Column limit that layer l (0 = first) must reach
    function automatic int layer_limit(input int w, input int l);
        return d_limit(n_layers(w) - l);
    endfunction

    // what: 0 = full adders, 1 = half adders, 2 = input height of the column
    function automatic int plan(input int w, input int lyr, input int col, input int what);
        int ht [MAX_COLS];
        int cin, f, h, cur, lim, res;
        res = 0;
        for (int c = 0; c < MAX_COLS; c++)
            ht[c] = (c < w) ? c + 1 : ((c < 2 * w) ? 2 * w - 1 - c : 0);
        for (int l = 0; l <= lyr; l++) begin
            lim = layer_limit(w, l);
            cin = 0;
            for (int c = 0; c < 2 * w; c++) begin
                f = 0;
                h = 0;
                cur = ht[c] + cin;
                while (cur > lim) begin
                    if (cur - lim >= 2) begin
                        f++;
                        cur -= 2;
                    end else begin
                        h++;
                        cur -= 1;
                    end
                end
                if (l == lyr && c == col)
                    res = (what == 0) ? f : ((what == 1) ? h : ht[c]);
                ht[c] = cur;
                cin = f + h;
            end
        end
        return res;
    endfunction

    // Total counters of one kind over the whole tree
    function automatic int counter_total(input int w, input int what);
        int t;
        t = 0;
        for (int l = 0; l < n_layers(w); l++)
            for (int c = 0; c < 2 * w; c++)
                t += plan(w, l, c, what);
        return t;
    endfunction

endpackage

// File: rtl/dadda_pp.sv
// Module dadda_pp
// Forms the W*W AND partial products and packs them by weight: column c
// holds every a[j]&b[i] with i+j == c, from the bottom row up. Unused
// rows of a column are tied to zero. Purely combinational.
module dadda_pp #(
    parameter int W = 16
) (
    input  logic [W-1:0]                op_a,
    input  logic [W-1:0]                op_b,
    output logic [2*W-1:0][W-1:0]       pp_cols
);

    localparam int NC = 2 * W;

    for (genvar c = 0; c < NC; c++) begin : g_col
        localparam int LO = (c < W) ? 0 : c - W + 1;
        localparam int HT = (c < W) ? c + 1 : NC - 1 - c;
        for (genvar r = 0; r < W; r++) begin : g_row
            // Each row is one AND gate, or a constant zero above the column height
            if (r < HT) begin : g_and
                assign pp_cols[c][r] = op_a[c - LO - r] & op_b[LO + r];
            end else begin : g_zero
                assign pp_cols[c][r] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/dadda_layer.sv
// Module dadda_layer
// One reduction layer. Column c applies the full and half adders chosen
// for it by the planner to its lowest input bits. The rest pass through,
// and the carries of column c-1 stack on top. Output column order is FA sums,
// HA sums, pass-through bits, incoming carries. Assumes the planner never
// asks for more counter inputs than the column holds.
module dadda_layer #(
    parameter int W   = 16,
    parameter int LYR = 0,
    parameter int OH  = 16
) (
    input  logic [2*W-1:0][W-1:0]  col_i,
    output logic [2*W-1:0][OH-1:0] col_o
);

    localparam int NC = 2 * W;

    logic [W-1:0] cy [NC-1];

    for (genvar c = 0; c < NC; c++) begin : g_col
        localparam int F  = dadda_pkg::plan(W, LYR, c, 0);
        localparam int H  = dadda_pkg::plan(W, LYR, c, 1);
        localparam int HI = dadda_pkg::plan(W, LYR, c, 2);
        localparam int K  = F + H;
        localparam int PT = HI - 3 * F - 2 * H;

        logic [W-1:0] cin;
        logic [W-1:0] sm;
        logic [W-1:0] nxt;

        if (c > 0) begin : g_cin
            assign cin = cy[c-1];
        end else begin : g_nocin
            assign cin = '0;
        end

        // Sum bits of this column's full and half adders
        always_comb begin
            sm = '0;
            for (int k = 0; k < F; k++)
                sm[k] = col_i[c][3*k] ^ col_i[c][3*k+1] ^ col_i[c][3*k+2];
            for (int k = 0; k < H; k++)
                sm[F+k] = col_i[c][3*F+2*k] ^ col_i[c][3*F+2*k+1];
        end

        if (c < NC - 1) begin : g_carry
            logic [W-1:0] co;
            // Carry bits of this column's counters, sent to column c+1
            always_comb begin
                co = '0;
                for (int k = 0; k < F; k++)
                    co[k] = (col_i[c][3*k] & col_i[c][3*k+1])
                          | (col_i[c][3*k] & col_i[c][3*k+2])
                          | (col_i[c][3*k+1] & col_i[c][3*k+2]);
                for (int k = 0; k < H; k++)
                    co[F+k] = col_i[c][3*F+2*k] & col_i[c][3*F+2*k+1];
            end
            assign cy[c] = co;
        end

        assign nxt = sm | ((col_i[c] >> (3 * F + 2 * H)) << K) | (cin << (K + PT));
        assign col_o[c] = nxt[OH-1:0];
    end

endmodule

// File: rtl/dadda_cpa.sv
// Module dadda_cpa
// Final carry-propagate adder. Splits the two-high columns into two row
// vectors and adds them. The carry out of the top column is dropped,
// because an unsigned W x W product always fits 2W bits.
module dadda_cpa #(
    parameter int W = 16
) (
    input  logic [2*W-1:0][1:0] rows,
    output logic [2*W-1:0]      sum
);

    logic [2*W-1:0] row_lo;
    logic [2*W-1:0] row_hi;

    // Split the column pairs into two addend rows
    always_comb begin
        for (int c = 0; c < 2 * W; c++) begin
            row_lo[c] = rows[c][0];
            row_hi[c] = rows[c][1];
        end
    end

    assign sum = row_lo + row_hi;

endmodule

// File: rtl/dadda_mult.sv
// Module dadda_mult
// Unsigned W x W Dadda tree multiplier: partial products, a planned chain
// of reduction layers, and a final adder. With REG_OUT = 1 the product and
// a valid flag are registered (one cycle latency, synchronous active-low
// reset). Otherwise the outputs are combinational and clk/rst_n are unused.
// Assumes 3 <= W <= 64.
module dadda_mult #(
    parameter int W       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic           op_vld,
    output logic [2*W-1:0] prod,
    output logic           prod_vld
);

    localparam int NC = 2 * W;
    localparam int NL = dadda_pkg::n_layers(W);

    logic [NL-1:0][NC-1:0][W-1:0] stg;
    logic [NC-1:0][1:0]           fin;
    logic [NC-1:0]                prod_c;

    dadda_pp #(.W(W)) u_pp (
        .op_a    (op_a),
        .op_b    (op_b),
        .pp_cols (stg[0])
    );

    for (genvar l = 0; l < NL; l++) begin : g_lay
        if (l < NL - 1) begin : g_mid
            dadda_layer #(.W(W), .LYR(l), .OH(W)) u_layer (
                .col_i (stg[l]),
                .col_o (stg[l+1])
            );
        end else begin : g_last
            dadda_layer #(.W(W), .LYR(l), .OH(2)) u_layer (
                .col_i (stg[l]),
                .col_o (fin)
            );
        end
    end

    dadda_cpa #(.W(W)) u_cpa (
        .rows (fin),
        .sum  (prod_c)
    );

    if (REG_OUT) begin : g_reg
        logic [NC-1:0] prod_q;
        logic          vld_q;
        // Output register: capture on valid, hold otherwise, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prod_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                vld_q <= op_vld;
                if (op_vld) prod_q <= prod_c;
            end
        end
        assign prod     = prod_q;
        assign prod_vld = vld_q;
    end else begin : g_comb
        assign prod     = prod_c;
        assign prod_vld = op_vld;
    end

endmodule

// File: rtl/dadda_mult_chk.sv
// Module dadda_mult_chk
// Checker for dadda_mult with a registered output: product value, LSB,
// zero operands, valid timing, holding and reset. Bound to every instance.
module dadda_mult_chk #(
    parameter int W       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [W-1:0]   op_a,
    input logic [W-1:0]   op_b,
    input logic           op_vld,
    input logic [2*W-1:0] prod,
    input logic           prod_vld
);

    localparam int PW = 2 * W;

    if (REG_OUT) begin : g_reg_chk
        AST_PRODUCT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_vld)) |-> (prod == (PW'($past(op_a)) * PW'($past(op_b))))); // R1

        AST_LSB_IS_AND: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_vld)) |-> (prod[0] == ($past(op_a[0]) & $past(op_b[0])))); // R3

        AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_vld) && ($past(op_a) == '0 || $past(op_b) == '0)) |-> (prod == '0)); // R4

        AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (prod_vld == $past(op_vld))); // R5

        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(op_vld)) |-> (prod == $past(prod))); // R6

        AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (prod == '0 && !prod_vld)); // R7
    end

endmodule

bind dadda_mult dadda_mult_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_a     (op_a),
    .op_b     (op_b),
    .op_vld   (op_vld),
    .prod     (prod),
    .prod_vld (prod_vld)
);

// File: tb/test_dadda_mult.sv
// Bench for dadda_mult: exhaustive 8-bit sweep, 16-bit corners and random
// operands, valid/hold/reset timing, and the elaboration-time schedule.
module test_dadda_mult;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic        v8 = 1'b0;
    logic [15:0] a16 = '0, b16 = '0;
    logic        v16 = 1'b0;
    logic [15:0] p8;
    logic [31:0] p16;
    logic        pv8, pv16;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dadda_mult #(.W(8), .REG_OUT(1'b1)) i_dadda_mult (
        .clk(clk), .rst_n(rst_n), .op_a(a8), .op_b(b8), .op_vld(v8),
        .prod(p8), .prod_vld(pv8)
    );

    dadda_mult #(.W(16), .REG_OUT(1'b1)) i_dadda_mult16 (
        .clk(clk), .rst_n(rst_n), .op_a(a16), .op_b(b16), .op_vld(v16),
        .prod(p16), .prod_vld(pv16)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one 16-bit pair at a falling edge, check the product one edge later
    task automatic mul16(input logic [15:0] a, input logic [15:0] b, input string tag);
        a16 = a; b16 = b; v16 = 1'b1;
        @(negedge clk);
        chk(tag, longint'(p16), longint'(a) * longint'(b));
    endtask

    localparam int LIM16 [6] = '{13, 9, 6, 4, 3, 2};
    localparam int LIM8  [4] = '{6, 4, 3, 2};

    initial begin
        logic [15:0] hold_val;
        logic [15:0] ra, rb;

        // R9: layer schedule
        chk("R9 layers W16", dadda_pkg::n_layers(16), 6);
        chk("R9 layers W8", dadda_pkg::n_layers(8), 4);
        for (int l = 0; l < 6; l++) chk("R9 limit W16", dadda_pkg::layer_limit(16, l), LIM16[l]);
        for (int l = 0; l < 4; l++) chk("R9 limit W8", dadda_pkg::layer_limit(8, l), LIM8[l]);
        // R8: counter totals against W^2-4W+3 and W-1
        chk("R8 FA W16", dadda_pkg::counter_total(16, 0), 16 * 16 - 4 * 16 + 3);
        chk("R8 HA W16", dadda_pkg::counter_total(16, 1), 15);
        chk("R8 FA W8", dadda_pkg::counter_total(8, 0), 35);
        chk("R8 HA W8", dadda_pkg::counter_total(8, 1), 7);

        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 reset prod", longint'(p8), 0);
        chk("R7 reset vld", longint'(pv8), 0);
        rst_n = 1'b1;

        // R1/R3/R4/R5: exhaustive 8-bit sweep, one pair per cycle
        for (int k = 0; k < 65536; k++) begin
            a8 = 8'(k >> 8); b8 = 8'(k); v8 = 1'b1;
            @(negedge clk);
            chk("R1 exhaustive 8x8", longint'(p8), longint'(k >> 8) * longint'(k & 255));
            if (k == 0) chk("R4 zero operands", longint'(p8), 0);
            if (k == 1) chk("R3 lsb 0x1", longint'(p8[0]), 0);
            if (k == 257) chk("R3 lsb 1x1", longint'(p8[0]), 1);
            if (k == 65535) begin
                chk("R10 all-ones square 8", longint'(p8), 65025);
                chk("R10 msb set 8", longint'(p8[15]), 1);
            end
            if (k == 5) chk("R5 valid high", longint'(pv8), 1);
        end

        // R6: operands change while valid is low, product holds
        hold_val = p8;
        v8 = 1'b0;
        for (int k = 0; k < 3; k++) begin
            a8 = 8'(37 * k + 11); b8 = 8'(91 * k + 5);
            @(negedge clk);
            chk("R6 hold while idle", longint'(p8), longint'(hold_val));
            chk("R5 valid low", longint'(pv8), 0);
        end

        // R2/R10: 16-bit corners and random pairs
        mul16(16'h0000, 16'h0000, "R2 0x0");
        mul16(16'h0000, 16'hFFFF, "R2 0xFFFF");
        mul16(16'hFFFF, 16'h0000, "R2 FFFFx0");
        mul16(16'h0001, 16'hFFFF, "R2 1xFFFF");
        mul16(16'hFFFF, 16'h0001, "R2 FFFFx1");
        mul16(16'h0001, 16'h0001, "R2 1x1");
        mul16(16'h8000, 16'h8000, "R2 8000x8000");
        mul16(16'hFFFF, 16'hFFFF, "R10 all-ones square 16");
        chk("R10 msb set 16", longint'(p16[31]), 1);
        for (int k = 0; k < 2000; k++) begin
            ra = 16'($urandom);
            rb = 16'($urandom);
            mul16(ra, rb, "R2 random");
        end

        // R7: reset while an operand is valid
        a8 = 8'hC3; b8 = 8'h5A; v8 = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        chk("R7 reset over valid prod", longint'(p8), 0);
        chk("R7 reset over valid vld", longint'(pv8), 0);
        v8 = 1'b0; v16 = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule